// File: doc/BRIEF.md
# Backlight Lamp Enable and Fault Supervisor

This block supervises the enable line of a backlight inverter. Software turns the lamp on and off through one bit in a control register, written over a byte-wide register port. Three comparator results arrive as digital levels: an over-current flag, a lamp-activity flag and an inverter startup-timeout flag. The block synchronises each of them and watches for two faults. The first is an over-current. The second is an open lamp, meaning the startup timeout expired after the lamp was enabled but before any lamp activity was seen.

Either fault is held in a sticky status bit and pulls the enable low at once. The only way to clear a fault is to write the control register again with the lamp bit set. If the fault condition is still present during that write, the fault stays set. A status register also shows the live lamp-on state. Both registers can be read combinationally through a separate read address.

Top module: `lamp_supervisor`

## Requirements
- R1: While reset is asserted and directly after it, `lamp_en` is 0, the control register (address 0x01) reads 0 and the status register (address 0x02) reads 0.
- R2: A write to address 0x01 loads `wr_data` bit 0 into the lamp-control bit. `lamp_en` equals that bit from the clock edge that takes the write, and reading 0x01 returns it in bit 0.
- R3: When the synchronised over-current level is high, status bit 2 (over-current) and status bit 0 (any fault) become 1 on the next edge. On that same edge the lamp-control bit is cleared and `lamp_en` goes to 0, so a status reading of 0x05 always comes with `lamp_en` low.
- R4: Fault bits stay set after their cause goes away. Writing 0x01 with bit 0 = 0, writing 0x02, and writing any other address all leave them unchanged.
- R5: A write to 0x01 with bit 0 = 1, made while no fault cause is active, clears status bits 0, 1 and 2 and sets `lamp_en`.
- R6: If a fault cause is active in the same cycle as a clearing write, the fault wins: the status bits stay set and `lamp_en` stays 0.
- R7: Status bit 3 is 1 while the synchronised lamp-activity level is 1 (lamp on), and 0 while it is 0 (lamp off).
- R8: After `lamp_en` rises, if the timeout level is seen before any lamp activity, status bit 1 (open lamp) and bit 0 are set (status 0x03) and `lamp_en` drops to 0.
- R9: If lamp activity is seen after `lamp_en` rises and before the timeout, a later timeout does not raise an open-lamp fault.
- R10: The held timeout flag is cleared by reset and on each rising edge of `lamp_en`. A timeout that came and went while the lamp was disabled therefore does not cause an open-lamp fault after the next enable.
- R11: Writes to any address other than 0x01 never change the lamp-control bit. Reads of any address other than 0x01 or 0x02 return 0, and unused register bits read 0.
- R12: Each comparator input passes through two synchroniser flops. A level applied before edge k shows in status bit 3 after edge k+1, and latches a fault at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Combinational read data |
| ovc_in | input | 1 | Over-current comparator level (asynchronous) |
| lamp_act_in | input | 1 | Lamp-activity comparator level (asynchronous) |
| tmo_in | input | 1 | Startup-timeout comparator level (asynchronous) |
| lamp_en | output | 1 | Inverter enable output |

## Verification
The bench builds the block with its defaults: an 8-bit data and address width, register addresses 0x01 and 0x02, and two synchroniser stages. The two-stage setting lets the bench count the exact edge on which a comparator level shows in status and the edge on which it latches a fault. The bench places a clearing write while over-current is still held high and checks that the fault survives the write. It also pulses the timeout while the lamp is disabled, which shows whether the held timeout is discarded when the enable rises.

// File: rtl/lamp_sup_pkg.sv
package lamp_sup_pkg;

   // Control register field
   localparam int CTRL_LAMP_BIT = 0;

   // Status register fields; packed so that bit 0 is the summary fault
   typedef struct packed {
      logic lamp_on;   // bit 3
      logic ovc;       // bit 2
      logic open;      // bit 1
      logic any;       // bit 0
   } stat_t;

   localparam int STAT_W = $bits(stat_t);

endpackage

// File: rtl/lamp_sync.sv
module lamp_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];

         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[0] <= '0;
                  else        stage_q[0] <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[s] <= '0;
                  else        stage_q[s] <= stage_q[s-1];
               end
            end
         end

         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lamp_fault_core.sv
module lamp_fault_core (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ctrl_hit,
   input  logic wr_lamp_bit,
   input  logic ovc_s,
   input  logic act_s,
   input  logic tmo_s,
   output logic ctrl_on,
   output logic fault_ovc,
   output logic fault_open,
   output logic armed,
   output logic tmo_held
);

   logic ctrl_prev_q;
   logic clear_req;
   logic open_set;
   logic en_rise;
   logic ovc_d, open_d, ctrl_d, tmo_d, armed_d;

   always_comb begin
      clear_req = wr_ctrl_hit & wr_lamp_bit;
      open_set  = armed & tmo_held & ~act_s;
      en_rise   = ctrl_on & ~ctrl_prev_q;

      // A new fault takes priority over a clearing write
      ovc_d  = ovc_s    | (fault_ovc  & ~clear_req);
      open_d = open_set | (fault_open & ~clear_req);

      ctrl_d = wr_ctrl_hit ? wr_lamp_bit : ctrl_on;
      if (ovc_d | open_d) ctrl_d = 1'b0;

      // Held timeout: discarded on each enable rise
      if (en_rise) tmo_d = 1'b0;
      else         tmo_d = tmo_held | tmo_s;

      // Open-lamp watch: armed by the rise, disarmed by activity or disable
      if (en_rise)                 armed_d = 1'b1;
      else if (act_s || !ctrl_on)  armed_d = 1'b0;
      else                         armed_d = armed;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_on     <= 1'b0;
         ctrl_prev_q <= 1'b0;
         fault_ovc   <= 1'b0;
         fault_open  <= 1'b0;
         tmo_held    <= 1'b0;
         armed       <= 1'b0;
      end else begin
         ctrl_on     <= ctrl_d;
         ctrl_prev_q <= ctrl_on;
         fault_ovc   <= ovc_d;
         fault_open  <= open_d;
         tmo_held    <= tmo_d;
         armed       <= armed_d;
      end
   end

endmodule

// File: rtl/lamp_reg_read.sv
module lamp_reg_read
   import lamp_sup_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h01,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h02
) (
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              ctrl_on,
   input  stat_t             stat,
   output logic [DATA_W-1:0] rd_data
);

   always_comb begin
      rd_data = '0;
      if (rd_addr == CTRL_ADDR) begin
         rd_data[CTRL_LAMP_BIT] = ctrl_on;
      end else if (rd_addr == STAT_ADDR) begin
         rd_data[STAT_W-1:0] = stat;
      end
   end

endmodule

// File: rtl/lamp_supervisor.sv
module lamp_supervisor
   import lamp_sup_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h01,
   parameter logic [ADDR_W-1:0] STAT_ADDR   = 'h02,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ovc_in,
   input  logic              lamp_act_in,
   input  logic              tmo_in,
   output logic              lamp_en
);

   localparam int NUM_CMP = 3;

   // Elaboration-time parameter checks
   generate
      if (DATA_W < STAT_W) begin : g_bad_width
         $error("lamp_supervisor: DATA_W must hold the status register");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("lamp_supervisor: SYNC_STAGES must be 0 (bypass) or at least 2");
      end
      if (CTRL_ADDR == STAT_ADDR) begin : g_bad_addr
         $error("lamp_supervisor: register addresses must differ");
      end
   endgenerate

   logic [NUM_CMP-1:0] cmp_raw, cmp_s;
   logic               ovc_s, act_s, tmo_s;
   logic               wr_ctrl_hit;
   logic               ctrl_on, fault_ovc, fault_open, armed, tmo_held;
   logic [DATA_W-1:0]  unused_wr_data;
   stat_t              stat;

   assign cmp_raw = {tmo_in, lamp_act_in, ovc_in};

   lamp_sync #(
      .WIDTH  (NUM_CMP),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_raw),
      .q     (cmp_s)
   );

   assign ovc_s = cmp_s[0];
   assign act_s = cmp_s[1];
   assign tmo_s = cmp_s[2];

   assign wr_ctrl_hit    = wr_en && (wr_addr == CTRL_ADDR);
   assign unused_wr_data = wr_data;

   lamp_fault_core u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ctrl_hit (wr_ctrl_hit),
      .wr_lamp_bit (wr_data[CTRL_LAMP_BIT]),
      .ovc_s       (ovc_s),
      .act_s       (act_s),
      .tmo_s       (tmo_s),
      .ctrl_on     (ctrl_on),
      .fault_ovc   (fault_ovc),
      .fault_open  (fault_open),
      .armed       (armed),
      .tmo_held    (tmo_held)
   );

   always_comb begin
      stat.lamp_on = act_s;
      stat.ovc     = fault_ovc;
      stat.open    = fault_open;
      stat.any     = fault_ovc | fault_open;
   end

   lamp_reg_read #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CTRL_ADDR (CTRL_ADDR),
      .STAT_ADDR (STAT_ADDR)
   ) u_read (
      .rd_addr (rd_addr),
      .ctrl_on (ctrl_on),
      .stat    (stat),
      .rd_data (rd_data)
   );

   assign lamp_en = ctrl_on;

endmodule

// File: rtl/lamp_supervisor_chk.sv
module lamp_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_ctrl_hit,
   input logic wr_bit0,
   input logic ovc_s,
   input logic lamp_en,
   input logic fault_ovc,
   input logic fault_open,
   input logic tmo_held
);

   // R3: any held fault keeps the enable low
   a_r3_fault_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_ovc || fault_open) |-> !lamp_en);

   // R4: over-current fault survives anything but a setting write to control
   a_r4_ovc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_ovc && !(wr_ctrl_hit && wr_bit0)) |=> fault_ovc);

   // R8: open-lamp fault is sticky in the same way
   a_r8_open_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_open && !(wr_ctrl_hit && wr_bit0)) |=> fault_open);

   // R8: open-lamp fault appears only after a held timeout
   a_r8_open_needs_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_open) |-> $past(tmo_held));

   // R5: a setting write with no active over-current clears it
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_ovc && wr_ctrl_hit && wr_bit0 && !ovc_s) |=> !fault_ovc);

   // R6: an active over-current wins over any write
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ovc_s |=> (fault_ovc && !lamp_en));

   // R2: writing 0 to the lamp bit turns the enable off
   a_r2_write_off: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl_hit && !wr_bit0) |=> !lamp_en);

   // R11: the enable rises only through a setting write to control
   a_r11_no_stray_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!lamp_en && !(wr_ctrl_hit && wr_bit0)) |=> !lamp_en);

endmodule

bind lamp_supervisor lamp_supervisor_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_ctrl_hit (wr_ctrl_hit),
   .wr_bit0     (wr_data[0]),
   .ovc_s       (ovc_s),
   .lamp_en     (lamp_en),
   .fault_ovc   (fault_ovc),
   .fault_open  (fault_open),
   .tmo_held    (tmo_held)
);

// File: tb/test_lamp_supervisor.sv
module test_lamp_supervisor;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       ovc_in = 1'b0;
   logic       lamp_act_in = 1'b0;
   logic       tmo_in = 1'b0;
   logic       lamp_en;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   lamp_supervisor i_lamp_supervisor (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .ovc_in      (ovc_in),
      .lamp_act_in (lamp_act_in),
      .tmo_in      (tmo_in),
      .lamp_en     (lamp_en)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      tick(2);
      check("R1 lamp_en in reset", {7'b0, lamp_en}, 8'h00);
      rst_n = 1'b1;
      tick(1);
      check("R1 lamp_en after reset", {7'b0, lamp_en}, 8'h00);
      rd(8'h01, v); check("R1 ctrl after reset", v, 8'h00);
      rd(8'h02, v); check("R1 status after reset", v, 8'h00);
   endtask

   task automatic t_enable;
      logic [7:0] v;
      wr(8'h01, 8'h01);
      check("R2 enable on", {7'b0, lamp_en}, 8'h01);
      rd(8'h01, v); check("R2 ctrl reads 1", v, 8'h01);
      wr(8'h01, 8'h00);
      check("R2 enable off", {7'b0, lamp_en}, 8'h00);
      rd(8'h01, v); check("R2 ctrl reads 0", v, 8'h00);
   endtask

   task automatic t_lamp_status;
      logic [7:0] v;
      lamp_act_in = 1'b1;
      tick(1);
      rd(8'h02, v); check("R12 lamp bit after one edge", v, 8'h00);
      tick(1);
      rd(8'h02, v); check("R7 lamp on bit3", v, 8'h08);
      lamp_act_in = 1'b0;
      tick(2);
      rd(8'h02, v); check("R7 lamp off bit3", v, 8'h00);
   endtask

   task automatic t_overcurrent;
      logic [7:0] v;
      wr(8'h01, 8'h01);
      ovc_in = 1'b1;
      tick(2);
      rd(8'h02, v); check("R12 no fault after two edges", v, 8'h00);
      check("R12 enable still on", {7'b0, lamp_en}, 8'h01);
      tick(1);
      rd(8'h02, v); check("R3 ovc status", v, 8'h05);
      check("R3 enable forced off", {7'b0, lamp_en}, 8'h00);
      rd(8'h01, v); check("R3 ctrl bit cleared", v, 8'h00);
      ovc_in = 1'b0;
      tick(4);
      rd(8'h02, v); check("R4 sticky after input low", v, 8'h05);
      wr(8'h01, 8'h00);
      rd(8'h02, v); check("R4 ctrl write 0 keeps fault", v, 8'h05);
      wr(8'h02, 8'hFF);
      rd(8'h02, v); check("R4 status write keeps fault", v, 8'h05);
      wr(8'h03, 8'h01);
      rd(8'h02, v); check("R4 other write keeps fault", v, 8'h05);
      check("R11 other write no enable", {7'b0, lamp_en}, 8'h00);
   endtask

   task automatic t_set_wins;
      logic [7:0] v;
      ovc_in = 1'b1;
      tick(3);
      wr(8'h01, 8'h01);
      rd(8'h02, v); check("R6 fault survives clear", v, 8'h05);
      check("R6 enable stays off", {7'b0, lamp_en}, 8'h00);
      ovc_in = 1'b0;
      tick(3);
   endtask

   task automatic t_clear;
      logic [7:0] v;
      wr(8'h01, 8'h01);
      rd(8'h02, v); check("R5 faults cleared", v, 8'h00);
      check("R5 enable on", {7'b0, lamp_en}, 8'h01);
      wr(8'h01, 8'h00);
   endtask

   task automatic t_open_lamp;
      logic [7:0] v;
      wr(8'h01, 8'h01);
      tick(2);
      tmo_in = 1'b1;
      tick(5);
      rd(8'h02, v); check("R8 open lamp status", v, 8'h03);
      check("R8 enable forced off", {7'b0, lamp_en}, 8'h00);
      tmo_in = 1'b0;
      tick(3);
      wr(8'h01, 8'h01);
      tick(4);
      rd(8'h02, v); check("R5 open lamp cleared", v, 8'h00);
      check("R5 enable back on", {7'b0, lamp_en}, 8'h01);
      wr(8'h01, 8'h00);
   endtask

   task automatic t_no_open;
      logic [7:0] v;
      wr(8'h01, 8'h01);
      lamp_act_in = 1'b1;
      tick(3);
      tmo_in = 1'b1;
      tick(5);
      rd(8'h02, v); check("R9 no open fault, lamp on", v, 8'h08);
      check("R9 enable stays on", {7'b0, lamp_en}, 8'h01);
      lamp_act_in = 1'b0;
      tmo_in = 1'b0;
      tick(4);
      rd(8'h02, v); check("R9 still no fault", v, 8'h00);
      wr(8'h01, 8'h00);
   endtask

   task automatic t_tmo_clear;
      logic [7:0] v;
      tmo_in = 1'b1;
      tick(4);
      tmo_in = 1'b0;
      tick(3);
      wr(8'h01, 8'h01);
      tick(5);
      rd(8'h02, v); check("R10 stale timeout discarded", v, 8'h00);
      check("R10 enable stays on", {7'b0, lamp_en}, 8'h01);
   endtask

   task automatic t_other_addr;
      logic [7:0] v;
      rd(8'h05, v); check("R11 unmapped read 0", v, 8'h00);
      wr(8'h01, 8'hFF);
      rd(8'h01, v); check("R11 unused ctrl bits 0", v, 8'h01);
      wr(8'h01, 8'h00);
      wr(8'h07, 8'h01);
      check("R11 stray write ignored", {7'b0, lamp_en}, 8'h00);
   endtask

   initial begin
      t_reset();
      t_enable();
      t_lamp_status();
      t_overcurrent();
      t_set_wins();
      t_clear();
      t_open_lamp();
      t_no_open();
      t_tmo_clear();
      t_other_addr();
      tick(2);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #4000000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule